// File: doc/BRIEF.md
# Compare-Triggered ADC Start Controller

This block produces periodic analog-to-digital sampling without software help. It holds two free-running 16-bit counters and a compare register. When the compare mode field is set to the trigger code and the selected counter reaches the compare value, the block clears that counter. If the converter is enabled and idle, the same event also starts a conversion. The counter restarts from zero on every match, so conversions repeat at a fixed period.

A conversion has two phases. First an acquisition wait runs, and its length comes from a 3-bit code. Then a one-cycle start pulse goes to the converter. The block waits for the converter's done strobe and then stores the 10-bit sample in a 16-bit result register, either left- or right-aligned. It clears its busy bit and raises an interrupt flag. Software configures the block and reads its state through a small register port.

Top module: `cmp_adc_trigger`

## Requirements
- R1: With the mode field (control bits 3:0) equal to 4'b1011, the counter chosen by control bit 6 (0 selects counter A, 1 selects counter B) is read as 0 in the cycle after it equals the compare value. The other counter keeps incrementing by one per cycle. The period of the chosen counter is therefore compare+1 cycles.
- R2: With any other mode value, the counters pass the compare value without being cleared and no conversion starts.
- R3: With the enable bit (control bit 4) clear, a match still clears the chosen counter. No start pulse is produced and busy (control bit 5) stays 0.
- R4: With the enable bit set and busy clear, a match sets busy.
- R5: The start pulse appears D cycles after busy is first seen high. D is 0, 2, 4, 6, 8, 12, 16 or 20 for acquisition code 0 to 7 (control bits 9:7).
- R6: On the done strobe, the result register (address 2) takes the sample. With the format bit (control bit 10) at 0 the sample occupies bits 9:0 and the upper bits are zero. With the format bit at 1 it occupies bits 15:6 and the lower bits are zero.
- R7: The done strobe clears busy and sets the interrupt flag (control bit 11). A control write with bit 11 at 1 leaves the flag unchanged. A control write with bit 11 at 0 clears it.
- R8: A match that occurs while busy is set clears the chosen counter but does not start a second conversion.
- R9: After reset, control and result read 0, the flag is 0 and no start pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also serves as the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0 control, 1 compare, 2 result, 3 counter A, 4 counter B |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr |
| conv_start | output | 1 | One-cycle pulse that starts conversion |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 10 | Converter sample, valid with conv_done |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest case to reach is a compare match that lands while a conversion is already under way. The bench produces it by starting a conversion with the longest acquisition wait. It then moves the compare value down to a few counts, so the freshly cleared counter matches again inside that wait. The bench counts start pulses across the whole conversion and checks that the counter was cleared a second time.

// File: rtl/cmp_adc_trigger.sv
module cmp_adc_trigger #(
  parameter int TW = 16,
  parameter int RW = 10,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] cfg_rdata,
  output logic          conv_start,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic          irq
);
  localparam logic [3:0] TRIG_MODE = 4'b1011;
  localparam int PAD = TW - RW;

  logic [TW-1:0] tmr_a, tmr_b, cmp_val, result;
  logic [3:0]    mode;
  logic [2:0]    acq_code;
  logic          en, sel, left_fmt, busy, converting;
  logic [CW-1:0] acq_cnt, acq_len;

  wire ctrl_wr = cfg_we && (cfg_addr == 3'd0);
  wire match   = (mode == TRIG_MODE) && ((sel ? tmr_b : tmr_a) == cmp_val);
  wire fire    = match && en && !busy;
  wire done_ev = busy && converting && conv_done;

  assign conv_start = busy && !converting && (acq_cnt == '0);

  always_comb begin
    case (acq_code)
      3'd0: acq_len = CW'(0);
      3'd1: acq_len = CW'(2);
      3'd2: acq_len = CW'(4);
      3'd3: acq_len = CW'(6);
      3'd4: acq_len = CW'(8);
      3'd5: acq_len = CW'(12);
      3'd6: acq_len = CW'(16);
      default: acq_len = CW'(20);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_a <= '0;
      tmr_b <= '0;
    end else begin
      tmr_a <= (match && !sel) ? '0 : tmr_a + 1'b1;
      tmr_b <= (match &&  sel) ? '0 : tmr_b + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; en <= 1'b0; sel <= 1'b0; acq_code <= '0; left_fmt <= 1'b0;
      cmp_val <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 3'd0) begin
        mode     <= cfg_wdata[3:0];
        en       <= cfg_wdata[4];
        sel      <= cfg_wdata[6];
        acq_code <= cfg_wdata[9:7];
        left_fmt <= cfg_wdata[10];
      end
      if (cfg_addr == 3'd1) cmp_val <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; converting <= 1'b0; acq_cnt <= '0; result <= '0; irq <= 1'b0;
    end else begin
      if (fire) begin
        busy <= 1'b1;
        converting <= 1'b0;
        acq_cnt <= acq_len;
      end else if (busy && !converting) begin
        if (acq_cnt == '0) converting <= 1'b1;
        else acq_cnt <= acq_cnt - 1'b1;
      end else if (done_ev) begin
        busy <= 1'b0;
        converting <= 1'b0;
        result <= left_fmt ? {conv_data, {PAD{1'b0}}} : {{PAD{1'b0}}, conv_data};
      end
      if (done_ev) irq <= 1'b1;
      else if (ctrl_wr && !cfg_wdata[11]) irq <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0: cfg_rdata = TW'({irq, left_fmt, acq_code, sel, busy, en, mode});
      3'd1: cfg_rdata = cmp_val;
      3'd2: cfg_rdata = result;
      3'd3: cfg_rdata = tmr_a;
      3'd4: cfg_rdata = tmr_b;
      default: cfg_rdata = '0;
    endcase
  end

  assert_timer_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !sel) |=> (tmr_a == '0));
  assert_no_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  assert_busy_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  assert_done_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (irq && !busy));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_ev) |=> busy);
endmodule

// File: tb/cmp_adc_trigger_test.sv
module cmp_adc_trigger_test;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, conv_done = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = '0, cfg_rdata, ctrl_sh;
  logic [9:0] conv_data = '0;
  logic conv_start, irq;
  int tests = 0, fails = 0, starts = 0, cycles = 0;

  cmp_adc_trigger uut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
                       .conv_start, .conv_done, .conv_data, .irq);

  always #5 clk = ~clk;
  always @(negedge clk) begin
    cycles++;
    if (conv_start) starts++;
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input logic [3:0] m, input logic e, input logic s,
                          input logic [2:0] c, input logic f);
    ctrl_sh = {4'b0, 1'b1, f, c, s, 1'b0, e, m};
    wr(3'd0, ctrl_sh);
  endtask

  function automatic int delay_of(input int c);
    return (c <= 4) ? 2 * c : 8 + 4 * (c - 4);
  endfunction

  task automatic arm(input logic s, input int ofs, output int c);
    logic [15:0] t;
    rd(s ? 3'd4 : 3'd3, t);
    c = int'(t) + ofs;
    wr(3'd1, 16'(c));
  endtask

  task automatic wait_timer(input logic s, input int c);
    logic [15:0] t;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); rd(s ? 3'd4 : 3'd3, t);
      if (int'(t) == c) break;
    end
  endtask

  task automatic wait_busy();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); rd(3'd0, v);
      if (v[5]) break;
    end
  endtask

  task automatic finish_conv(input logic [9:0] d);
    repeat (3) @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic conv_run(input int code, input logic f, input logic s, input logic [9:0] d);
    logic [15:0] v;
    int c, n;
    set_ctrl(4'b1011, 1'b1, s, 3'(code), f);
    arm(s, 60, c);
    wait_busy();
    rd(3'd0, v); chk("R4 busy set on match", v[5], 1);
    n = 0;
    while (!conv_start && n < 40) begin @(negedge clk); n++; end
    chk("R5 acquisition delay", n, delay_of(code));
    finish_conv(d);
    rd(3'd0, v);
    chk("R7 busy cleared", v[5], 0);
    chk("R7 flag set", irq, 1);
    rd(3'd2, v);
    chk("R6 result alignment", v, f ? (int'(d) * 64) : int'(d));
    set_ctrl(4'b0000, 1'b1, s, 3'(code), f);
    chk("R7 flag held on write 1", irq, 1);
    wr(3'd0, ctrl_sh & 16'hF7FF);
    chk("R7 flag cleared on write 0", irq, 0);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, a0, b0;
    int c, s0, zero_seen, busy_low;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R9 control after reset", v, 0);
    rd(3'd2, v); chk("R9 result after reset", v, 0);
    chk("R9 flag after reset", irq, 0);
    chk("R9 no start after reset", conv_start, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      set_ctrl(4'b1011, 1'b0, s[0], 3'd0, 1'b0);
      arm(s[0], 20, c);
      wait_timer(s[0], c);
      rd(3'd3, a0); rd(3'd4, b0);
      s0 = starts;
      @(negedge clk);
      rd(s[0] ? 3'd4 : 3'd3, v); chk("R1 chosen counter cleared", v, 0);
      rd(s[0] ? 3'd3 : 3'd4, v);
      chk("R1 other counter runs", v, (s[0] ? int'(a0) : int'(b0)) + 1);
      for (int k = 1; k <= c; k++) @(negedge clk);
      rd(s[0] ? 3'd4 : 3'd3, v); chk("R1 period equals compare+1", v, c);
      @(negedge clk);
      rd(s[0] ? 3'd4 : 3'd3, v); chk("R1 repeat clear", v, 0);
      rd(3'd0, v); chk("R3 busy stays clear", v[5], 0);
      chk("R3 no start when disabled", starts - s0, 0);
    end

    set_ctrl(4'b1010, 1'b1, 1'b0, 3'd0, 1'b0);
    arm(1'b0, 20, c);
    wait_timer(1'b0, c);
    s0 = starts;
    @(negedge clk);
    rd(3'd3, v); chk("R2 no clear in other mode", v, c + 1);
    repeat (30) @(negedge clk);
    chk("R2 no start in other mode", starts - s0, 0);

    for (int code = 0; code < 8; code++)
      for (int f = 0; f < 2; f++)
        conv_run(code, f[0], code[0], 10'((code * 97 + f * 301 + 5) & 1023));
    conv_run(0, 1'b0, 1'b0, 10'h3FF);
    conv_run(0, 1'b1, 1'b1, 10'h3FF);
    conv_run(1, 1'b1, 1'b0, 10'h000);

    set_ctrl(4'b1011, 1'b1, 1'b0, 3'd7, 1'b0);
    arm(1'b0, 30, c);
    wait_busy();
    s0 = starts;
    wr(3'd1, 16'd5);
    zero_seen = 0; busy_low = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rd(3'd3, v); if (v == 0) zero_seen++;
      rd(3'd0, v); if (!v[5]) busy_low++;
    end
    chk("R8 counter cleared while busy", zero_seen > 0, 1);
    chk("R8 busy not dropped", busy_low, 0);
    set_ctrl(4'b0000, 1'b1, 1'b0, 3'd7, 1'b0);
    for (int k = 0; k < 40 && !conv_start; k++) @(negedge clk);
    finish_conv(10'h155);
    chk("R8 single start pulse", starts - s0, 1);
    rd(3'd2, v); chk("R8 result of single conversion", v, 16'h0155);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule